// File: doc/BRIEF.md
# Receive Buffer Resource Manager

This block keeps track of the buffers a receiver may fill. Software lays out a circular table of buffer descriptors in memory. Each entry holds a 32-bit buffer address and a 32-bit count of free 16-bit words, and every field is one 16-bit word. Four 16-bit pointers share one upper address word and describe the ring: start, end, read and write. On request the block fetches the entry under the read pointer through a 16-bit memory read port. It then loads the current buffer address and word count, and moves the read pointer to the next entry, wrapping at the end pointer.

For each received frame a strobe reports its length. The block adds the 4 CRC bytes and rounds the sum up to the bus alignment. If the result fits the buffer, it advances the buffer address and lowers the word count. If the count then falls below a threshold, or the frame did not fit, the packet is the last one for this buffer. The block then fetches the next resource. When the ring is used up it stalls instead, and discards frames until software supplies more entries.

A fetch is run by a small state machine:

- `ST_IDLE` leaves for `ST_RD_BA_LO` when a fetch is pending.
- `ST_RD_BA_LO` moves to `ST_RD_BA_HI` on a memory acknowledge.
- `ST_RD_BA_HI` moves to `ST_RD_WC_LO` on an acknowledge.
- `ST_RD_WC_LO` moves to `ST_RD_WC_HI` on an acknowledge.
- `ST_RD_WC_HI` moves to `ST_ADVANCE` on an acknowledge.
- `ST_ADVANCE` updates the read pointer, wraps it and checks for exhaustion, then always returns to `ST_IDLE`.

Packets are only processed in `ST_IDLE` when no fetch is pending.

Top module: `rx_rsrc_mgr`

## Requirements
- R1: After reset the block is idle: busy, stall, last_pkt, both status bits, mem_rd_req, pkt_done and pkt_drop are 0, and buf_addr, word_cnt and read_ptr are 0.
- R2: A fetch issues four reads at {upper, read_ptr + k*S} for k = 0..3, with S = 2 in 16-bit mode and S = 4 in 32-bit mode. The words are loaded in that order into buffer address low, buffer address high, word count low and word count high. The read pointer then advances by 4*S. A request is held with a stable address until acknowledged, and busy is 1 while a fetch is pending or running.
- R3: If the advanced read pointer equals the end pointer, it is reloaded with the start pointer.
- R4: If the read pointer after the advance and wrap equals the write pointer, stat_exhaust is set.
- R5: Register writes use address 0 for start, 1 for end, 2 for read pointer, 3 for write pointer, 4 for upper address word, 5 for threshold and 6 for mode (bit 0 = 32-bit mode). Pointer writes clear bit 0 in 16-bit mode and bits 1:0 in 32-bit mode.
- R6: A frame of length L uses P = L+4 rounded up to a multiple of 2 bytes (16-bit mode) or 4 bytes (32-bit mode). When it fits, buf_addr increases by P and word_cnt decreases by P/2.
- R7: last_pkt is set when the word count after a packet is strictly below the threshold. The threshold resets to 0x02F8, and a count equal to it does not set the flag.
- R8: If P exceeds twice word_cnt, stat_overflow and last_pkt are set, the frame is dropped (pkt_drop pulse) and the buffer state is unchanged.
- R9: When last_pkt is set and read_ptr differs from the write pointer, a fetch follows. When they are equal, stall is set instead and no fetch is made.
- R10: While stall is 1, every frame is discarded with a pkt_drop pulse and leaves buf_addr and word_cnt unchanged. A fetch clears stall.
- R11: A write to address 7 acts on command bits. Bit 0 requests a fetch. Bit 4 clears stat_overflow. Bit 5 clears stat_exhaust and requests a fetch, but only if stat_exhaust was 1; otherwise it does nothing.
- R12: A packet strobe that arrives while busy is held, and is applied to the buffer loaded by the fetch once that fetch ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | PTR_W | Register write data |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 2*PTR_W | Memory read byte address |
| mem_rd_ack | input | 1 | Memory read accepted, data valid |
| mem_rd_data | input | PTR_W | Memory read data |
| pkt_valid | input | 1 | One-cycle strobe: a frame was received |
| pkt_len | input | LEN_W | Frame length in bytes without CRC |
| busy | output | 1 | Fetch or packet pending or in progress |
| buf_addr | output | 2*PTR_W | Current buffer address |
| word_cnt | output | 2*PTR_W | Remaining words in the current buffer |
| read_ptr | output | PTR_W | Descriptor table read pointer |
| last_pkt | output | 1 | The latest processed packet ended this buffer |
| stall | output | 1 | Resources exhausted, frames discarded |
| stat_overflow | output | 1 | Buffer area exceeded status |
| stat_exhaust | output | 1 | Buffers exhausted status |
| pkt_done | output | 1 | Pulse: a packet was processed |
| pkt_drop | output | 1 | Pulse: the processed packet was dropped |

## Verification
The hardest state to reach is the stall: the ring must be walked until the read pointer lands on the write pointer, and then a frame must overflow the buffer just loaded. The stimulus builds a six-entry ring with small word counts in the later entries. It drives frames that push the block from the threshold case through an overflow fetch into exhaustion, and then into a stalled overflow. Discarding is then shown on a frame that would fit. Clearing the exhausted status restarts fetching, and a later fetch crosses the end pointer to show the wrap. A packet strobe issued one cycle after a fetch command checks that a held frame lands in the newly loaded buffer.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_BA_LO,
        ST_RD_BA_HI,
        ST_RD_WC_LO,
        ST_RD_WC_HI,
        ST_ADVANCE
    } rrm_state_e;

    localparam logic [2:0] RA_START  = 3'd0;
    localparam logic [2:0] RA_END    = 3'd1;
    localparam logic [2:0] RA_RDPTR  = 3'd2;
    localparam logic [2:0] RA_WRPTR  = 3'd3;
    localparam logic [2:0] RA_UPPER  = 3'd4;
    localparam logic [2:0] RA_THRESH = 3'd5;
    localparam logic [2:0] RA_MODE   = 3'd6;
    localparam logic [2:0] RA_CMD    = 3'd7;

    localparam int CMD_FETCH_BIT   = 0;
    localparam int CMD_CLR_OVF_BIT = 4;
    localparam int CMD_CLR_EXH_BIT = 5;

    localparam logic [15:0] THRESH_RESET = 16'h02F8;

endpackage

// File: rtl/rrm_cfg_regs.sv
module rrm_cfg_regs
    import rrm_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             rp_load,
    input  logic [PTR_W-1:0] rp_load_val,
    output logic [PTR_W-1:0] start_ptr,
    output logic [PTR_W-1:0] end_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] upper,
    output logic [PTR_W-1:0] thresh,
    output logic             wide
);

    logic [PTR_W-1:0] align_mask;
    logic [PTR_W-1:0] aligned;

    always_comb begin
        align_mask = '1;
        align_mask[0] = 1'b0;
        if (wide) begin
            align_mask[1] = 1'b0;
        end
        aligned = wr_data & align_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_ptr <= '0;
            end_ptr   <= '0;
            wr_ptr    <= '0;
            upper     <= '0;
            thresh    <= PTR_W'(THRESH_RESET);
            wide      <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                RA_START:  start_ptr <= aligned;
                RA_END:    end_ptr   <= aligned;
                RA_WRPTR:  wr_ptr    <= aligned;
                RA_UPPER:  upper     <= wr_data;
                RA_THRESH: thresh    <= wr_data;
                RA_MODE:   wide      <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rp_load) begin
            rd_ptr <= rp_load_val;
        end else if (wr_en && wr_addr == RA_RDPTR) begin
            rd_ptr <= aligned;
        end
    end

endmodule

// File: rtl/rrm_len_calc.sv
module rrm_len_calc #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 32
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic             wide,
    input  logic [CNT_W-1:0] word_cnt,
    output logic [LEN_W:0]   pad_len,
    output logic             fits,
    output logic [CNT_W-1:0] wc_after
);

    localparam int PW = LEN_W + 1;

    logic [PW-1:0] with_crc;
    logic [PW-1:0] round_mask;

    always_comb begin
        with_crc   = PW'(frame_len) + PW'(4);
        round_mask = wide ? PW'(3) : PW'(1);
        pad_len    = ((with_crc - PW'(1)) | round_mask) + PW'(1);
        fits       = ((CNT_W+1)'(pad_len)) <= {word_cnt, 1'b0};
        wc_after   = word_cnt - CNT_W'(pad_len >> 1);
    end

endmodule

// File: rtl/rx_rsrc_mgr.sv
module rx_rsrc_mgr
    import rrm_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [PTR_W-1:0]     wr_data,
    output logic                 mem_rd_req,
    output logic [2*PTR_W-1:0]   mem_rd_addr,
    input  logic                 mem_rd_ack,
    input  logic [PTR_W-1:0]     mem_rd_data,
    input  logic                 pkt_valid,
    input  logic [LEN_W-1:0]     pkt_len,
    output logic                 busy,
    output logic [2*PTR_W-1:0]   buf_addr,
    output logic [2*PTR_W-1:0]   word_cnt,
    output logic [PTR_W-1:0]     read_ptr,
    output logic                 last_pkt,
    output logic                 stall,
    output logic                 stat_overflow,
    output logic                 stat_exhaust,
    output logic                 pkt_done,
    output logic                 pkt_drop
);

    localparam int CNT_W  = 2 * PTR_W;
    localparam int ADDR_W = 2 * PTR_W;

    rrm_state_e state, state_nxt;

    logic [PTR_W-1:0] start_ptr, end_ptr, rd_ptr, wr_ptr, upper, thresh;
    logic             wide;
    logic             rp_load;
    logic [PTR_W-1:0] rp_adv, rp_wrapped;
    logic [PTR_W-1:0] fld_off;
    logic [1:0]       fld_idx;

    logic             fetch_pend, pkt_pend;
    logic [LEN_W-1:0] len_q;
    logic             fetch_start, pkt_go;
    logic             cmd_wr, cmd_fetch, cmd_clr_ovf, cmd_clr_exh;
    logic             pkt_last, pkt_fetch, pkt_stall;

    logic [LEN_W:0]   pad_len;
    logic             fits;
    logic [CNT_W-1:0] wc_after;

    rrm_cfg_regs #(.PTR_W(PTR_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rp_load     (rp_load),
        .rp_load_val (rp_wrapped),
        .start_ptr   (start_ptr),
        .end_ptr     (end_ptr),
        .rd_ptr      (rd_ptr),
        .wr_ptr      (wr_ptr),
        .upper       (upper),
        .thresh      (thresh),
        .wide        (wide)
    );

    rrm_len_calc #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_len (
        .frame_len (len_q),
        .wide      (wide),
        .word_cnt  (word_cnt),
        .pad_len   (pad_len),
        .fits      (fits),
        .wc_after  (wc_after)
    );

    // command decode
    always_comb begin
        cmd_wr      = wr_en && (wr_addr == RA_CMD);
        cmd_fetch   = cmd_wr && wr_data[CMD_FETCH_BIT];
        cmd_clr_ovf = cmd_wr && wr_data[CMD_CLR_OVF_BIT];
        cmd_clr_exh = cmd_wr && wr_data[CMD_CLR_EXH_BIT] && stat_exhaust;
    end

    // scheduling and packet decisions
    always_comb begin
        fetch_start = (state == ST_IDLE) && fetch_pend;
        pkt_go      = (state == ST_IDLE) && !fetch_pend && pkt_pend;
        pkt_last    = !fits || (wc_after < CNT_W'(thresh));
        pkt_fetch   = pkt_go && !stall && pkt_last && (rd_ptr != wr_ptr);
        pkt_stall   = pkt_go && !stall && pkt_last && (rd_ptr == wr_ptr);
    end

    // descriptor addressing
    always_comb begin
        unique case (state)
            ST_RD_BA_HI: fld_idx = 2'd1;
            ST_RD_WC_LO: fld_idx = 2'd2;
            ST_RD_WC_HI: fld_idx = 2'd3;
            default:     fld_idx = 2'd0;
        endcase
        fld_off     = wide ? (PTR_W'(fld_idx) << 2) : (PTR_W'(fld_idx) << 1);
        rp_adv      = rd_ptr + (wide ? PTR_W'(16) : PTR_W'(8));
        rp_wrapped  = (rp_adv == end_ptr) ? start_ptr : rp_adv;
        rp_load     = (state == ST_ADVANCE);
        mem_rd_req  = (state == ST_RD_BA_LO) || (state == ST_RD_BA_HI) ||
                      (state == ST_RD_WC_LO) || (state == ST_RD_WC_HI);
        mem_rd_addr = {upper, rd_ptr + fld_off};
        busy        = (state != ST_IDLE) || fetch_pend || pkt_pend;
        read_ptr    = rd_ptr;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (fetch_pend) state_nxt = ST_RD_BA_LO;
            ST_RD_BA_LO: if (mem_rd_ack) state_nxt = ST_RD_BA_HI;
            ST_RD_BA_HI: if (mem_rd_ack) state_nxt = ST_RD_WC_LO;
            ST_RD_WC_LO: if (mem_rd_ack) state_nxt = ST_RD_WC_HI;
            ST_RD_WC_HI: if (mem_rd_ack) state_nxt = ST_ADVANCE;
            ST_ADVANCE:  state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_pend    <= 1'b0;
            pkt_pend      <= 1'b0;
            len_q         <= '0;
            buf_addr      <= '0;
            word_cnt      <= '0;
            last_pkt      <= 1'b0;
            stall         <= 1'b0;
            stat_overflow <= 1'b0;
            stat_exhaust  <= 1'b0;
            pkt_done      <= 1'b0;
            pkt_drop      <= 1'b0;
        end else begin
            pkt_done   <= 1'b0;
            pkt_drop   <= 1'b0;
            fetch_pend <= cmd_fetch || cmd_clr_exh || pkt_fetch ||
                          (fetch_pend && !fetch_start);
            pkt_pend   <= pkt_valid || (pkt_pend && !pkt_go);
            if (pkt_valid) begin
                len_q <= pkt_len;
            end

            if (mem_rd_req && mem_rd_ack) begin
                unique case (state)
                    ST_RD_BA_LO: buf_addr[PTR_W-1:0]     <= mem_rd_data;
                    ST_RD_BA_HI: buf_addr[ADDR_W-1:PTR_W] <= mem_rd_data;
                    ST_RD_WC_LO: word_cnt[PTR_W-1:0]     <= mem_rd_data;
                    ST_RD_WC_HI: word_cnt[CNT_W-1:PTR_W]  <= mem_rd_data;
                    default: ;
                endcase
            end

            if (state == ST_ADVANCE) begin
                stall <= 1'b0;
            end else if (pkt_stall) begin
                stall <= 1'b1;
            end

            if (state == ST_ADVANCE && rp_wrapped == wr_ptr) begin
                stat_exhaust <= 1'b1;
            end else if (cmd_clr_exh) begin
                stat_exhaust <= 1'b0;
            end

            if (pkt_go && !stall && !fits) begin
                stat_overflow <= 1'b1;
            end else if (cmd_clr_ovf) begin
                stat_overflow <= 1'b0;
            end

            if (pkt_go) begin
                pkt_done <= 1'b1;
                if (stall) begin
                    pkt_drop <= 1'b1;
                    last_pkt <= 1'b0;
                end else if (fits) begin
                    buf_addr <= buf_addr + ADDR_W'(pad_len);
                    word_cnt <= wc_after;
                    last_pkt <= pkt_last;
                end else begin
                    pkt_drop <= 1'b1;
                    last_pkt <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rx_rsrc_mgr_chk.sv
module rx_rsrc_mgr_chk
    import rrm_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input rrm_state_e         state,
    input logic               mem_rd_req,
    input logic               mem_rd_ack,
    input logic [2*PTR_W-1:0] mem_rd_addr,
    input logic               stall,
    input logic [PTR_W-1:0]   read_ptr,
    input logic [PTR_W-1:0]   wr_ptr,
    input logic               stat_exhaust,
    input logic               pkt_done,
    input logic               pkt_drop,
    input logic [2*PTR_W-1:0] buf_addr,
    input logic [2*PTR_W-1:0] word_cnt
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R4
    exhaust_at_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_exhaust) |-> $past(state == ST_ADVANCE));

    // R5
    rp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !read_ptr[0]);

    // R9
    stall_on_meet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(read_ptr == wr_ptr));

    // R10
    stall_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && $past(stall)) |-> (pkt_drop && $stable(buf_addr) && $stable(word_cnt)));

    // R6
    count_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !pkt_drop) |-> (word_cnt < $past(word_cnt)));

endmodule

bind rx_rsrc_mgr rx_rsrc_mgr_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_ack   (mem_rd_ack),
    .mem_rd_addr  (mem_rd_addr),
    .stall        (stall),
    .read_ptr     (read_ptr),
    .wr_ptr       (wr_ptr),
    .stat_exhaust (stat_exhaust),
    .pkt_done     (pkt_done),
    .pkt_drop     (pkt_drop),
    .buf_addr     (buf_addr),
    .word_cnt     (word_cnt)
);

// File: tb/rx_rsrc_mgr_test.sv
module rx_rsrc_mgr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack;
    logic [15:0] mem_rd_data;
    logic        pkt_valid = 1'b0;
    logic [15:0] pkt_len = '0;
    logic        busy;
    logic [31:0] buf_addr, word_cnt;
    logic [15:0] read_ptr;
    logic        last_pkt, stall, stat_overflow, stat_exhaust, pkt_done, pkt_drop;

    logic [15:0] mem [0:63];
    logic [15:0] alog [0:63];
    int          acnt = 0;
    int          drop_cnt = 0;
    int          tests = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    assign mem_rd_ack  = mem_rd_req;
    assign mem_rd_data = mem[mem_rd_addr[6:1]];

    rx_rsrc_mgr uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .busy(busy), .buf_addr(buf_addr), .word_cnt(word_cnt), .read_ptr(read_ptr),
        .last_pkt(last_pkt), .stall(stall), .stat_overflow(stat_overflow),
        .stat_exhaust(stat_exhaust), .pkt_done(pkt_done), .pkt_drop(pkt_drop)
    );

    always @(negedge clk) begin
        if (mem_rd_req && acnt < 64) begin
            alog[acnt] = mem_rd_addr[15:0];
            acnt = acnt + 1;
        end
        if (pkt_drop) drop_cnt = drop_cnt + 1;
    end

    localparam int NV = 5;
    localparam logic [15:0] VLEN [NV] = '{16'd60, 16'd61, 16'd62, 16'd63, 16'd1};
    localparam logic [15:0] VPAD [NV] = '{16'd64, 16'd66, 16'd66, 16'd68, 16'd6};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
    endtask

    task automatic send(input logic [15:0] len);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = len;
        @(negedge clk);
        pkt_valid = 1'b0;
        wait_idle();
    endtask

    task automatic put_entry(input int byte_addr, input int step, input logic [31:0] ba,
                             input logic [31:0] wc);
        mem[(byte_addr >> 1)]              = ba[15:0];
        mem[((byte_addr + step) >> 1)]     = ba[31:16];
        mem[((byte_addr + 2*step) >> 1)]   = wc[15:0];
        mem[((byte_addr + 3*step) >> 1)]   = wc[31:16];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] exp_ba, exp_wc;
        int d0, a0;
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        put_entry(16'h10, 2, 32'h0002_1000, 32'h0000_02FA);
        put_entry(16'h18, 2, 32'h0000_3000, 32'h0000_0100);
        put_entry(16'h20, 2, 32'h0000_5000, 32'h0000_0040);
        put_entry(16'h28, 2, 32'h0000_7000, 32'h0000_0008);
        put_entry(16'h30, 2, 32'h0000_9000, 32'h0000_0020);
        put_entry(16'h38, 2, 32'h0000_B000, 32'h0000_0010);
        put_entry(16'h40, 4, 32'h0000_D000, 32'h0000_0100);
        put_entry(16'h50, 4, 32'h0000_F000, 32'h0000_0100);

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle outputs", {22'd0, busy, stall, last_pkt, stat_overflow, stat_exhaust,
            mem_rd_req, pkt_done, pkt_drop, 2'b00}, 32'd0);
        chk("R1 buf_addr", buf_addr, 32'd0);
        chk("R1 word_cnt", word_cnt, 32'd0);
        chk("R1 read_ptr", {16'd0, read_ptr}, 32'd0);

        wreg(3'd0, 16'h0010);
        wreg(3'd1, 16'h0040);
        wreg(3'd2, 16'h0010);
        wreg(3'd3, 16'h0030);
        wreg(3'd4, 16'h0000);
        a0 = acnt;
        wreg(3'd7, 16'h0001);
        chk("R2 fetch buf_addr", buf_addr, 32'h0002_1000);
        chk("R2 fetch word_cnt", word_cnt, 32'h0000_02FA);
        chk("R2 read_ptr step", {16'd0, read_ptr}, 32'h18);
        chk("R2 read order 16-bit", {alog[a0], alog[a0+3]}, {16'h0010, 16'h0016});

        // default threshold 0x02F8: equality does not mark last
        send(16'd0);
        chk("R7 equal threshold buf_addr", buf_addr, 32'h0002_1004);
        chk("R7 equal threshold count", word_cnt, 32'h0000_02F8);
        chk("R7 equal threshold last", {31'd0, last_pkt}, 32'd0);
        send(16'd0);
        chk("R7 below threshold last", {31'd0, last_pkt}, 32'd1);
        chk("R9 next resource buf_addr", buf_addr, 32'h0000_3000);
        chk("R9 next resource ptr", {16'd0, read_ptr}, 32'h20);

        wreg(3'd5, 16'h0010);
        exp_ba = 32'h3000;
        exp_wc = 32'h100;
        for (int i = 0; i < NV; i++) begin
            send(VLEN[i]);
            exp_ba = exp_ba + 32'(VPAD[i]);
            exp_wc = exp_wc - 32'(VPAD[i] >> 1);
            chk("R6 table buf_addr", buf_addr, exp_ba);
            chk("R6 table word_cnt", word_cnt, exp_wc);
            chk("R7 table last", {31'd0, last_pkt}, 32'd0);
        end

        wreg(3'd5, 16'h0070);
        send(16'd20);
        chk("R7 threshold fetch buf", buf_addr, 32'h5000);
        chk("R7 threshold fetch ptr", {16'd0, read_ptr}, 32'h28);

        wreg(3'd5, 16'h0000);
        d0 = drop_cnt;
        send(16'd200);
        chk("R8 overflow drop", 32'(drop_cnt - d0), 32'd1);
        chk("R8 overflow status", {31'd0, stat_overflow}, 32'd1);
        chk("R8 overflow last", {31'd0, last_pkt}, 32'd1);
        chk("R4 exhaust set", {31'd0, stat_exhaust}, 32'd1);
        chk("R9 fetch after overflow", buf_addr, 32'h7000);
        chk("R9 ptr meets write ptr", {16'd0, read_ptr}, 32'h30);

        send(16'd20);
        chk("R9 stall set", {31'd0, stall}, 32'd1);
        chk("R9 no fetch on stall", buf_addr, 32'h7000);
        d0 = drop_cnt;
        send(16'd4);
        chk("R10 discard drop", 32'(drop_cnt - d0), 32'd1);
        chk("R10 discard buf", buf_addr, 32'h7000);
        chk("R10 discard count", word_cnt, 32'h8);

        wreg(3'd7, 16'h0010);
        chk("R11 clear overflow", {30'd0, stat_overflow, stat_exhaust}, 32'd1);
        chk("R11 overflow clear no fetch", {16'd0, read_ptr}, 32'h30);
        wreg(3'd7, 16'h0020);
        chk("R11 exhaust cleared", {31'd0, stat_exhaust}, 32'd0);
        chk("R10 stall cleared", {31'd0, stall}, 32'd0);
        chk("R11 clear fetched", buf_addr, 32'h9000);
        chk("R11 clear fetch ptr", {16'd0, read_ptr}, 32'h38);
        wreg(3'd7, 16'h0020);
        chk("R11 ignored clear ptr", {16'd0, read_ptr}, 32'h38);
        chk("R11 ignored clear buf", buf_addr, 32'h9000);

        wreg(3'd7, 16'h0001);
        chk("R3 wrap ptr", {16'd0, read_ptr}, 32'h10);
        chk("R3 wrap buf", buf_addr, 32'hB000);
        chk("R4 no exhaust after wrap", {31'd0, stat_exhaust}, 32'd0);
        send(16'd0);
        chk("R10 reception resumed", buf_addr, 32'hB004);

        wreg(3'd2, 16'h0013);
        chk("R5 align 16-bit", {16'd0, read_ptr}, 32'h12);
        wreg(3'd6, 16'h0001);
        wreg(3'd2, 16'h0043);
        chk("R5 align 32-bit", {16'd0, read_ptr}, 32'h40);
        wreg(3'd0, 16'h0041);
        wreg(3'd1, 16'h0060);
        wreg(3'd3, 16'h0050);
        a0 = acnt;
        wreg(3'd7, 16'h0001);
        chk("R2 read order 32-bit", {alog[a0], alog[a0+1], alog[a0+2], alog[a0+3]},
            {16'h0040, 16'h0044, 16'h0048, 16'h004C});
        chk("R2 wide buf", buf_addr, 32'hD000);
        chk("R2 wide ptr", {16'd0, read_ptr}, 32'h50);
        chk("R4 wide exhaust", {31'd0, stat_exhaust}, 32'd1);
        send(16'd61);
        chk("R6 wide pad buf", buf_addr, 32'hD044);
        chk("R6 wide pad count", word_cnt, 32'd222);

        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'h0020;
        @(negedge clk);
        wr_en = 1'b0;
        pkt_valid = 1'b1; pkt_len = 16'd0;
        @(negedge clk);
        pkt_valid = 1'b0;
        wait_idle();
        chk("R12 held packet buf", buf_addr, 32'hF004);
        chk("R12 held packet count", word_cnt, 32'hFE);
        chk("R3 wide wrap", {16'd0, read_ptr}, 32'h40);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule